// File: doc/BRIEF.md
# Two-Stage Interrupt Priority Controller

This block collects up to 63 level-sensitive interrupt request lines and picks a single winning request on each clock. The choice runs in two stages. The interrupt level is compared first, and level 7 is the most urgent. Among requests on the same level, the priority within that level decides. Sources 1 to 7 are hardwired. Source n always requests on level n, at a rank that sits in the middle of that level's programmable priorities. Sources 8 to 63 each own a small control register that assigns their level and their in-level priority.

The winner is presented as a registered level, source number and vector number. A separate request flag is raised only when the winning level is strictly above the processor's current priority mask. A processor sitting at mask m therefore never sees a request at level m or lower. A plain write/read port lets software program and inspect the control registers.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A source s (1 to 63) takes part in arbitration only while its line irq_in[s] is high and its effective level is nonzero. Requests are level sensitive and are not latched.
- R2: The control register of source s (8 to 63) sits at cfg_addr = s. Bits [5:3] hold the level and bits [2:0] the in-level priority, where 7 is the highest. A write takes effect at the clock edge. cfg_rdata shows the addressed register combinationally as {2'b00, level, priority}, so bits [7:6] always read zero.
- R3: Addresses 0 to 7 have no register. Writes to them are ignored, reads return zero, and the fixed sources keep their level.
- R4: A programmable source whose level field is 0 never wins, whatever its line and priority.
- R5: Fixed source n (1 to 7) requests on level n. On that level it beats programmable priorities 3, 2, 1 and 0, and it loses to programmable priorities 7, 6, 5 and 4.
- R6: A request on a higher level beats any request on a lower level, regardless of in-level priority.
- R7: On the same level, a higher programmable priority beats a lower one.
- R8: When two programmable sources share the same level and priority, the lower-numbered source wins.
- R9: The outputs irq_valid, irq_level, irq_src and irq_vector are registered and reflect the inputs present at the previous rising edge. irq_vector equals 64 + irq_src. When no source is eligible, all four outputs are zero.
- R10: irq_req is high exactly when a winner exists and its level is strictly greater than the mask_in sampled at the same edge. A mask of 7 blocks every level, and a mask of 0 passes levels 1 to 7.
- R11: An active-high synchronous reset clears every control register to zero and all outputs to zero. After reset, only the fixed sources 1 to 7 can win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 63 ([63:1]) | Request lines, bit s belongs to source s |
| mask_in | input | 3 | Current processor priority mask |
| cfg_we | input | 1 | Control register write strobe |
| cfg_addr | input | 6 | Source number addressed by the register port |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the addressed register |
| irq_valid | output | 1 | A winning request exists |
| irq_req | output | 1 | Winner is above the mask, interrupt the processor |
| irq_level | output | 3 | Level of the winner |
| irq_src | output | 6 | Source number of the winner |
| irq_vector | output | 8 | Vector number, 64 + source |

## Verification
The bench builds the block with its default of 63 sources and 7 fixed sources. This gives every level the full set of eight programmable slots plus its fixed midpoint slot. The fixed-versus-programmable boundary between priorities 4 and 3 can be reached on each level, as can equal-rank ties between distant source numbers and the top source 63 at the edge of the 64-leaf selection tree. Random register contents, sparse request patterns and masks then exercise the complete level-then-priority ordering against a model that ranks candidates with its own numeric key.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int LVL_W  = 3;
  localparam int PRI_W  = 3;
  localparam int RANK_W = PRI_W + 1;
  localparam int SRC_W  = 6;
  localparam int VEC_W  = 8;

  // Rank inside a level: programmable 7..4 -> 8..5, fixed -> 4, programmable 3..0 -> 3..0
  localparam logic [RANK_W-1:0] MID_RANK = RANK_W'(4);

  typedef struct packed {
    logic              vld;
    logic [LVL_W-1:0]  lvl;
    logic [RANK_W-1:0] rank;
    logic [SRC_W-1:0]  src;
  } cand_t;

  function automatic logic [RANK_W-1:0] prio_to_rank(input logic [PRI_W-1:0] p);
    if (p >= PRI_W'(4)) return {1'b0, p} + RANK_W'(1);
    return {1'b0, p};
  endfunction

  // true when a should be kept over b; equal keys keep a (the lower-numbered side)
  function automatic logic cand_beats(input cand_t a, input cand_t b);
    if (!a.vld) return 1'b0;
    if (!b.vld) return 1'b1;
    return {a.lvl, a.rank} >= {b.lvl, b.rank};
  endfunction

  function automatic logic lvl_above_mask(input logic [LVL_W-1:0] lvl,
                                          input logic [LVL_W-1:0] mask);
    return lvl > mask;
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] src, input int base);
    return VEC_W'(base + int'(src));
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC   = 63,
  parameter int NUM_FIXED = 7
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [SRC_W-1:0]               addr,
  input  logic [LVL_W+PRI_W-1:0]         wr_data,
  output logic [7:0]                     rd_data,
  output logic [NUM_SRC:1][LVL_W-1:0]    lvl_o,
  output logic [NUM_SRC:1][RANK_W-1:0]   rank_o
);

  localparam int CFG_W = LVL_W + PRI_W;

  logic [NUM_SRC:1][CFG_W-1:0] cfg_view;

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    if (s > NUM_FIXED) begin : g_prog
      logic [CFG_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                              q <= '0;
        else if (wr_en && int'(addr) == s)    q <= wr_data;
      end
      assign cfg_view[s] = q;
      assign lvl_o[s]    = q[CFG_W-1:PRI_W];
      assign rank_o[s]   = prio_to_rank(q[PRI_W-1:0]);
    end else begin : g_fixed
      assign cfg_view[s] = '0;
      assign lvl_o[s]    = LVL_W'(s);
      assign rank_o[s]   = MID_RANK;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int s = NUM_FIXED + 1; s <= NUM_SRC; s++) begin
      if (int'(addr) == s) rd_data = {2'b00, cfg_view[s]};
    end
  end

endmodule

// File: rtl/irq_cand_tree.sv
module irq_cand_tree
  import irq_prio_pkg::*;
#(
  parameter int LEAVES = 64
) (
  input  cand_t [LEAVES-1:0] leaf_i,
  output cand_t              win_o
);

  localparam int DEPTH = $clog2(LEAVES);

  for (genvar st = 0; st <= DEPTH; st++) begin : g_st
    localparam int N = LEAVES >> st;
    cand_t [N-1:0] node;
    if (st == 0) begin : g_in
      assign node = leaf_i;
    end else begin : g_cmp
      for (genvar k = 0; k < N; k++) begin : g_n
        assign node[k] = cand_beats(g_st[st-1].node[2*k], g_st[st-1].node[2*k+1])
                       ? g_st[st-1].node[2*k] : g_st[st-1].node[2*k+1];
      end
    end
  end

  assign win_o = g_st[DEPTH].node[0];

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
  import irq_prio_pkg::*;
#(
  parameter int VEC_BASE = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  cand_t            win_i,
  input  logic [LVL_W-1:0] mask_i,
  output logic             above_mask_o,
  output logic             valid_o,
  output logic             req_o,
  output logic [LVL_W-1:0] level_o,
  output logic [SRC_W-1:0] src_o,
  output logic [VEC_W-1:0] vector_o
);

  assign above_mask_o = win_i.vld && lvl_above_mask(win_i.lvl, mask_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      req_o    <= 1'b0;
      level_o  <= '0;
      src_o    <= '0;
      vector_o <= '0;
    end else begin
      valid_o  <= win_i.vld;
      req_o    <= above_mask_o;
      level_o  <= win_i.vld ? win_i.lvl : '0;
      src_o    <= win_i.vld ? win_i.src : '0;
      vector_o <= win_i.vld ? vec_of(win_i.src, VEC_BASE) : '0;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC   = 63,
  parameter int NUM_FIXED = 7,
  parameter int VEC_BASE  = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC:1]   irq_in,
  input  logic [LVL_W-1:0]   mask_in,
  input  logic               cfg_we,
  input  logic [SRC_W-1:0]   cfg_addr,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  output logic               irq_valid,
  output logic               irq_req,
  output logic [LVL_W-1:0]   irq_level,
  output logic [SRC_W-1:0]   irq_src,
  output logic [VEC_W-1:0]   irq_vector
);

  localparam int LEAVES = 1 << $clog2(NUM_SRC + 1);

  logic [NUM_SRC:1][LVL_W-1:0]  src_lvl;
  logic [NUM_SRC:1][RANK_W-1:0] src_rank;
  cand_t [LEAVES-1:0]           leaf_c;
  cand_t                        win_c;
  logic                         win_above_mask;
  logic                         unused_wdata_hi;

  assign unused_wdata_hi = ^cfg_wdata[7:6];

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .addr    (cfg_addr),
    .wr_data (cfg_wdata[LVL_W+PRI_W-1:0]),
    .rd_data (cfg_rdata),
    .lvl_o   (src_lvl),
    .rank_o  (src_rank)
  );

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k >= 1 && k <= NUM_SRC) begin : g_src
      assign leaf_c[k].vld  = irq_in[k] && (src_lvl[k] != '0);
      assign leaf_c[k].lvl  = src_lvl[k];
      assign leaf_c[k].rank = src_rank[k];
      assign leaf_c[k].src  = SRC_W'(k);
    end else begin : g_pad
      assign leaf_c[k] = '0;
    end
  end

  irq_cand_tree #(.LEAVES(LEAVES)) tree_i (
    .leaf_i (leaf_c),
    .win_o  (win_c)
  );

  irq_out_stage #(.VEC_BASE(VEC_BASE)) out_i (
    .clk          (clk),
    .rst          (rst),
    .win_i        (win_c),
    .mask_i       (mask_in),
    .above_mask_o (win_above_mask),
    .valid_o      (irq_valid),
    .req_o        (irq_req),
    .level_o      (irq_level),
    .src_o        (irq_src),
    .vector_o     (irq_vector)
  );

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC   = 63,
  parameter int NUM_FIXED = 7,
  parameter int VEC_BASE  = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] mask_in,
  input logic             cfg_we,
  input logic [SRC_W-1:0] cfg_addr,
  input logic [5:0]       cfg_wdata,
  input logic [7:0]       cfg_rdata,
  input logic             irq_valid,
  input logic             irq_req,
  input logic [LVL_W-1:0] irq_level,
  input logic [SRC_W-1:0] irq_src,
  input logic [VEC_W-1:0] irq_vector,
  input cand_t            win_c,
  input logic             win_above_mask
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_req_above_mask_R10: assert property (@(posedge clk) disable iff (rst)
    armed && irq_req |-> irq_level > $past(mask_in));

  assert_req_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    armed && irq_valid && irq_level <= $past(mask_in) |-> !irq_req);

  assert_req_from_winner_R10: assert property (@(posedge clk) disable iff (rst)
    armed && $past(win_above_mask) |-> irq_req && irq_valid);

  assert_vector_R9: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> int'(irq_vector) == VEC_BASE + int'(irq_src));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |-> irq_level == '0 && irq_src == '0 && irq_vector == '0 && !irq_req);

  assert_reg_stage_R9: assert property (@(posedge clk) disable iff (rst)
    armed && $past(win_c.vld) |-> irq_valid && irq_src == $past(win_c.src)
                                  && irq_level == $past(win_c.lvl));

  assert_fixed_level_R5: assert property (@(posedge clk) disable iff (rst)
    irq_valid && int'(irq_src) <= NUM_FIXED |-> int'(irq_level) == int'(irq_src));

  assert_level_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> irq_level != '0 && irq_src != '0);

  assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
    armed && $past(cfg_we) && int'($past(cfg_addr)) > NUM_FIXED
      && int'($past(cfg_addr)) <= NUM_SRC && cfg_addr == $past(cfg_addr) && !cfg_we
      |-> cfg_rdata == {2'b00, $past(cfg_wdata)});

  assert_fixed_addr_zero_R3: assert property (@(posedge clk) disable iff (rst)
    int'(cfg_addr) <= NUM_FIXED |-> cfg_rdata == 8'h00);

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> !irq_valid && !irq_req && irq_vector == '0);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED), .VEC_BASE(VEC_BASE)
) chk_i (
  .clk            (clk),
  .rst            (rst),
  .mask_in        (mask_in),
  .cfg_we         (cfg_we),
  .cfg_addr       (cfg_addr),
  .cfg_wdata      (cfg_wdata[5:0]),
  .cfg_rdata      (cfg_rdata),
  .irq_valid      (irq_valid),
  .irq_req        (irq_req),
  .irq_level      (irq_level),
  .irq_src        (irq_src),
  .irq_vector     (irq_vector),
  .win_c          (win_c),
  .win_above_mask (win_above_mask)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:1] irq_in = '0;
  logic [2:0]  mask_in = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        irq_valid, irq_req;
  logic [2:0]  irq_level;
  logic [5:0]  irq_src;
  logic [7:0]  irq_vector;

  int total = 0;
  int bad   = 0;
  logic [5:0] cfg_m [64];

  always #2.5 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask_in(mask_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_valid(irq_valid), .irq_req(irq_req), .irq_level(irq_level),
    .irq_src(irq_src), .irq_vector(irq_vector)
  );

  // Reference: numeric key lvl*32 + slot, slot = 2p (p<=3), 7 (fixed), 2p+2 (p>=4)
  function automatic void model_win(input logic [63:1] irq, input logic [2:0] m,
                                    output logic v, output logic [2:0] l,
                                    output logic [5:0] s, output logic r);
    int best;
    best = -1; v = 1'b0; l = '0; s = '0;
    for (int i = 1; i <= 63; i++) begin
      int lv, slot, key;
      if (i <= 7) begin
        lv = i; slot = 7;
      end else begin
        lv = int'(cfg_m[i][5:3]);
        slot = (int'(cfg_m[i][2:0]) > 3) ? 2*int'(cfg_m[i][2:0]) + 2 : 2*int'(cfg_m[i][2:0]);
      end
      key = lv*32 + slot;
      if (irq[i] && lv != 0 && key > best) begin
        best = key; v = 1'b1; l = 3'(lv); s = 6'(i);
      end
    end
    r = v && (l > m);
  endfunction

  task automatic tick_check(input bit ok, input string req, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  task automatic cmp_out(input string req, input logic v, input logic [2:0] l,
                         input logic [5:0] s, input logic r);
    logic [7:0] ev;
    ev = v ? 8'(64 + int'(s)) : 8'h00;
    tick_check(irq_valid == v && irq_level == l && irq_src == s && irq_req == r && irq_vector == ev,
               req, $sformatf("actual v=%0b l=%0d s=%0d req=%0b vec=%0d expected v=%0b l=%0d s=%0d req=%0b vec=%0d",
                              irq_valid, irq_level, irq_src, irq_req, irq_vector, v, l, s, r, ev));
  endtask

  task automatic step(input logic [63:1] irq, input logic [2:0] m, input string req);
    logic v, r; logic [2:0] l; logic [5:0] s;
    @(negedge clk);
    irq_in = irq; mask_in = m;
    model_win(irq, m, v, l, s, r);
    @(negedge clk);
    cmp_out(req, v, l, s, r);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a >= 8) cfg_m[a] = d[5:0];
  endtask

  task automatic rd(input int a, input string req);
    logic [7:0] e;
    @(negedge clk);
    cfg_addr = 6'(a);
    #1;
    e = (a >= 8) ? {2'b00, cfg_m[a]} : 8'h00;
    tick_check(cfg_rdata == e, req, $sformatf("addr %0d actual %02h expected %02h", a, cfg_rdata, e));
  endtask

  function automatic logic [63:1] bits(input int a, input int b = 0, input int c = 0);
    logic [63:1] x;
    x = '0;
    if (a > 0) x[a] = 1'b1;
    if (b > 0) x[b] = 1'b1;
    if (c > 0) x[c] = 1'b1;
    return x;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) cfg_m[i] = '0;
    cmp_out("R11", 1'b0, 3'd0, 6'd0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog run did not complete actual timeout expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] rnd;
    logic [63:1] prev_irq;
    logic pv, pr; logic [2:0] pl; logic [5:0] ps;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) cfg_m[i] = '0;
    irq_in = bits(40, 20);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state with lines already asserted (none of them fixed)
    cmp_out("R11", 1'b0, 3'd0, 6'd0, 1'b0);
    rd(20, "R11");
    step(bits(40, 20), 3'd0, "R11");
    // R1 R5 R6: fixed sources only after reset
    step(bits(3, 6), 3'd0, "R6");
    step(bits(1), 3'd0, "R1");
    step('0, 3'd0, "R1");
    // R5 boundary on level 6
    wr(10, 8'h34);
    wr(11, 8'h33);
    step(bits(6, 10), 3'd0, "R5");
    step(bits(6, 11), 3'd0, "R5");
    // R6 level beats priority
    wr(12, 8'h2F);
    wr(13, 8'h38);
    step(bits(12, 13), 3'd0, "R6");
    // R7 within level
    wr(14, 8'h22);
    wr(15, 8'h26);
    step(bits(14, 15), 3'd0, "R7");
    // R8 tie to the lower source
    wr(20, 8'h1D);
    wr(18, 8'h1D);
    step(bits(20, 18), 3'd0, "R8");
    wr(63, 8'h1D);
    step(bits(63, 20), 3'd0, "R8");
    // R4 level zero disables
    wr(40, 8'h07);
    step(bits(40), 3'd0, "R4");
    step(bits(40, 2), 3'd0, "R4");
    // R10 mask
    step(bits(13), 3'd7, "R10");
    step(bits(13), 3'd6, "R10");
    step(bits(5), 3'd5, "R10");
    step(bits(5), 3'd4, "R10");
    step(bits(1), 3'd0, "R10");
    // R3 writes to fixed addresses ignored
    wr(5, 8'h3F);
    wr(0, 8'h3F);
    rd(5, "R3");
    rd(0, "R3");
    step(bits(5, 4), 3'd0, "R3");
    // R2 readback, upper bits dropped
    wr(30, 8'hFF);
    rd(30, "R2");
    rd(14, "R2");
    step(bits(30, 13, 15), 3'd0, "R2");
    // R9 outputs hold until the next edge
    @(negedge clk);
    irq_in = bits(2); mask_in = 3'd0;
    #1;
    cmp_out("R9", 1'b1, 3'd7, 6'd30, 1'b1);
    @(negedge clk);
    cmp_out("R9", 1'b1, 3'd2, 6'd2, 1'b1);
    // random mix
    prev_irq = '0;
    for (int it = 0; it < 600; it++) begin
      if ($urandom_range(0, 3) == 0) wr(int'($urandom_range(0, 63)), 8'($urandom));
      if ($urandom_range(0, 1) == 0)
        rnd = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      else
        rnd = {$urandom & $urandom, $urandom & $urandom};
      step(rnd[63:1], 3'($urandom_range(0, 7)), it % 2 == 0 ? "R6" : "R7");
      if (it % 50 == 0) rd(int'($urandom_range(0, 63)), "R2");
      prev_irq = rnd[63:1];
    end
    model_win(prev_irq, mask_in, pv, pl, ps, pr);
    // R11 reset mid-run clears programmed sources
    do_reset();
    rd(30, "R11");
    step(bits(30, 13, 3), 3'd0, "R11");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule